// File: doc/BRIEF.md
# Row and Column Bypassing Array Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. Internally it is a carry-save array: a first stage of partial products, then one adder row per remaining multiplier bit, and a ripple-carry stage that resolves the last pair of sum and carry vectors into the upper product bits.

Cells with nothing to add are skipped. If a multiplier bit is zero, the whole adder row for that bit is bypassed. If a multiplicand bit is zero, that column's cells are bypassed. A bypassed cell forwards its incoming sum through a mux, sends out a zero carry, and has its adder inputs forced to zero so they do not toggle. A cell only does work when both of its operand bits are one. In that case its partial-product bit is a known one, so the cell is an incrementer (x + y + 1) rather than a general full adder.

Carries that a bypassed row would otherwise have absorbed are sent to a correction path. That path adds them back at the correct weight, so the product stays exact. A parameter adds an optional output register with a synchronous reset.

Top module: `bypmul`

## Requirements
- R1: For all operand values, `p` equals the unsigned product `a * b`, 2N bits wide.
- R2: With REG_OUT=1, `p` shows the product of the operands sampled at the previous rising edge of `clk` and holds it until the next edge. With REG_OUT=0, `p` follows the operands combinationally.
- R3: With REG_OUT=1, a high `rst` at a rising edge clears `p` to zero regardless of the operands.
- R4: In adder row j (1 to N-1), if `b[j]` is 0 then every cell in that row gives a zero carry, and the row's sum vector equals the previous row's sum vector shifted down by one position, with zero entering the top.
- R5: If `a[i]` is 0, the cell in column i of every row gives a zero carry.
- R6: Carries that enter a bypassed row go to the correction path at weight 2^j for row j. When bits 1 to N-1 of `b` are all one, the correction value is zero. When `b` has zero bits above bit 0 and the operands produce carries into those rows, the product is still exact.
- R7: A cell whose operand bits `a[i]` and `b[j]` are both one produces the 2-bit result (carry, sum) equal to its sum input plus its carry input plus one.
- R8: A zero in either operand gives a zero product. All-ones operands give (2^N - 1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| p | output | 2N | Unsigned product |

## Verification
The bench builds two instances. The first uses N=4 with the output register. It sweeps all 256 operand pairs, so every combination of bypassed rows and columns passes through the correction path and the reset and latency behaviour. The second uses N=8 without the register. It takes alternating-bit, all-zero, all-ones and single-bit corner patterns plus a few hundred random pairs, which reaches long runs of bypassed rows that the narrow instance cannot produce.

// File: rtl/bypmul_pkg.sv
package bypmul_pkg;

    // generic full-adder sum bit
    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    // generic full-adder carry bit
    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (x & ci) | (y & ci);
    endfunction

    // incrementer cell: third addend is the constant one
    function automatic logic inc_sum(input logic x, input logic y);
        return ~(x ^ y);
    endfunction

    function automatic logic inc_carry(input logic x, input logic y);
        return x | y;
    endfunction

endpackage

// File: rtl/bypmul_cell.sv
module bypmul_cell
    import bypmul_pkg::*;
(
    input  logic x,      // sum from previous row, same weight
    input  logic y,      // carry from previous row, same weight
    input  logic a_bit,
    input  logic b_bit,
    output logic s,
    output logic c
);
    logic en;
    logic gx, gy;

    // the cell adds only when its partial product is one
    assign en = a_bit & b_bit;
    // operand gating keeps an idle cell quiet
    assign gx = x & en;
    assign gy = y & en;

    // bypass muxes: forward the sum, emit no carry
    assign s = en ? inc_sum(gx, gy)   : x;
    assign c = en ? inc_carry(gx, gy) : 1'b0;
endmodule

// File: rtl/bypmul_row.sv
module bypmul_row #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic         bj,
    input  logic [N-1:0] s_in,
    input  logic [N-1:0] c_in,
    output logic [N-1:0] s_out,
    output logic [N-1:0] c_out,
    output logic [N-1:0] fix_out
);
    // carries stranded by a skipped row leave through the correction path
    assign fix_out = bj ? '0 : c_in;

    for (genvar i = 0; i < N; i++) begin : g_col
        logic xin;
        if (i == N - 1) begin : g_top
            assign xin = 1'b0;
        end else begin : g_mid
            assign xin = s_in[i+1];
        end
        bypmul_cell u_cell (
            .x     (xin),
            .y     (c_in[i]),
            .a_bit (a[i]),
            .b_bit (bj),
            .s     (s_out[i]),
            .c     (c_out[i])
        );
    end
endmodule

// File: rtl/bypmul_resolve.sv
module bypmul_resolve
    import bypmul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:1]   s_hi,   // last-row sums, weights N .. 2N-2
    input  logic [N-1:0]   c_last, // last-row carries, weights N .. 2N-1
    input  logic [N-1:0]   low,    // product bits 0 .. N-1
    input  logic [2*N-1:0] corr,   // accumulated bypassed carries
    output logic [2*N-1:0] prod
);
    localparam int PW = 2 * N;

    logic [N-1:0] op1;
    logic [N-1:0] cry;
    logic [N-1:0] upper;

    assign cry[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_rca
        if (k < N - 1) begin : g_op
            assign op1[k]   = s_hi[k+1];
            assign cry[k+1] = fa_carry(op1[k], c_last[k], cry[k]);
        end else begin : g_msb
            assign op1[k] = 1'b0;
        end
        assign upper[k] = fa_sum(op1[k], c_last[k], cry[k]);
    end

    // correcting adder restores bypassed carries
    assign prod = PW'({upper, low}) + corr;
endmodule

// File: rtl/bypmul.sv
module bypmul #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam int PW = 2 * N;

    logic [N-1:0][N-1:0]  s_row;
    logic [N-1:0][N-1:0]  c_row;
    logic [N-1:0][N-1:0]  fix_row;
    logic [N-1:0][PW-1:0] corr_acc;
    logic [N-1:0]         low_bits;
    logic [PW-1:0]        prod_comb;

    // stage zero: partial products of b[0], no carries yet
    assign s_row[0]    = a & {N{b[0]}};
    assign c_row[0]    = '0;
    assign fix_row[0]  = '0;
    assign corr_acc[0] = '0;

    for (genvar j = 1; j < N; j++) begin : g_row
        bypmul_row #(.N(N)) u_row (
            .a       (a),
            .bj      (b[j]),
            .s_in    (s_row[j-1]),
            .c_in    (c_row[j-1]),
            .s_out   (s_row[j]),
            .c_out   (c_row[j]),
            .fix_out (fix_row[j])
        );
        assign corr_acc[j] = corr_acc[j-1] + (PW'(fix_row[j]) << j);
    end

    for (genvar j = 0; j < N; j++) begin : g_low
        assign low_bits[j] = s_row[j][0];
    end

    bypmul_resolve #(.N(N)) u_res (
        .s_hi   (s_row[N-1][N-1:1]),
        .c_last (c_row[N-1]),
        .low    (low_bits),
        .corr   (corr_acc[N-1]),
        .prod   (prod_comb)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [PW-1:0] prod;
        } out_t;

        out_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.prod = prod_comb;
        end

        always_ff @(posedge clk) begin
            if (rst) st_q <= '0;
            else     st_q <= st_d;
        end

        assign p = st_q.prod;
    end else begin : g_comb
        assign p = prod_comb;
    end
endmodule

// File: rtl/bypmul_chk.sv
module bypmul_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N-1:0]          a,
    input logic [N-1:0]          b,
    input logic [2*N-1:0]        p,
    input logic [N-1:0][N-1:0]   s_row,
    input logic [N-1:0][N-1:0]   c_row,
    input logic [2*N-1:0]        corr
);
    localparam int PW = 2 * N;

    if (REG_OUT) begin : g_seq
        // R1, R2: one-cycle latency, exact product
        a_r1_exact_reg: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> p == $past(PW'(a) * PW'(b)));
        // R3: reset clears the output
        a_r3_reset_clear: assert property (@(posedge clk)
            rst |=> p == '0);
    end else begin : g_cmb
        // R1, R2: combinational exact product
        a_r1_exact_comb: assert property (@(posedge clk) disable iff (rst)
            p == PW'(a) * PW'(b));
    end

    // R6: a multiplier with no zero above bit 0 leaves nothing to correct
    a_r6_no_fix: assert property (@(posedge clk) disable iff (rst)
        (&b[N-1:1]) |-> corr == '0);

    for (genvar j = 1; j < N; j++) begin : g_rj
        // R4: skipped row forwards shifted sums and emits no carry
        a_r4_row_bypass: assert property (@(posedge clk) disable iff (rst)
            !b[j] |-> (c_row[j] == '0) && (s_row[j] == {1'b0, s_row[j-1][N-1:1]}));

        for (genvar i = 0; i < N; i++) begin : g_ci
            logic xv;
            if (i == N - 1) begin : g_t
                assign xv = 1'b0;
            end else begin : g_m
                assign xv = s_row[j-1][i+1];
            end
            // R7: active cell is an incrementer
            a_r7_inc_cell: assert property (@(posedge clk) disable iff (rst)
                (a[i] && b[j]) |->
                {c_row[j][i], s_row[j][i]} == 2'(xv) + 2'(c_row[j-1][i]) + 2'd1);
            // R5: zero multiplicand bit keeps the column carry-free
            a_r5_col_bypass: assert property (@(posedge clk) disable iff (rst)
                !a[i] |-> c_row[j][i] == 1'b0);
        end
    end
endmodule

bind bypmul bypmul_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .a     (a),
    .b     (b),
    .p     (p),
    .s_row (s_row),
    .c_row (c_row),
    .corr  (corr_acc[N-1])
);

// File: tb/tb_bypmul.sv
module tb_bypmul;
    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    logic        rst;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic [7:0]  a8, b8;
    logic [15:0] p8;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_en = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    bypmul #(.N(4), .REG_OUT(1'b1)) dut (
        .clk (clk), .rst (rst), .a (a4), .b (b4), .p (p4));

    bypmul #(.N(8), .REG_OUT(1'b0)) dut_w8 (
        .clk (clk), .rst (rst), .a (a8), .b (b8), .p (p8));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: apply operands to the registered instance, queue the expectation
    task automatic drive4(input logic [3:0] x, input logic [3:0] y, input string req);
        item_t it;
        @(negedge clk);
        a4 = x;
        b4 = y;
        it.exp = {4'b0, x} * {4'b0, y};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: compare just after the edge that registers the product
    always @(posedge clk) begin
        #1;
        if (mon_en && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, {8'b0, p4}, {8'b0, it.exp});
        end
    end

    task automatic drive8(input logic [7:0] x, input logic [7:0] y, input string req);
        a8 = x;
        b8 = y;
        #1;
        check(req, p8, {8'b0, x} * {8'b0, y});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        a4  = '0; b4 = '0;
        a8  = '0; b8 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset state", {8'b0, p4}, 16'h0);
        a4 = 4'hF; b4 = 4'hF;
        @(posedge clk); #1;
        check("R3 reset beats operands", {8'b0, p4}, 16'h0);
        @(negedge clk);
        rst    = 1'b0;
        mon_en = 1'b1;

        // targeted bypass patterns
        drive4(4'hF, 4'b0101, "R4 row bypass");
        drive4(4'b0110, 4'hF, "R5 column bypass");
        drive4(4'hF, 4'b0011, "R6 correction path");
        drive4(4'hF, 4'b1011, "R6 correction path");
        drive4(4'hF, 4'hF, "R7 all cells active");
        drive4(4'h0, 4'h9, "R8 zero multiplicand");

        // exhaustive sweep
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                if (x == 0 || y == 0)       drive4(4'(x), 4'(y), "R8 zero operand");
                else if (x == 15 && y == 15) drive4(4'(x), 4'(y), "R8 all ones");
                else                         drive4(4'(x), 4'(y), "R1 exhaustive");
            end
        end
        repeat (3) @(posedge clk);
        mon_en = 1'b0;

        // R2: output holds until the next edge, then updates
        @(negedge clk);
        a4 = 4'd9; b4 = 4'd7;
        #1;
        check("R2 holds previous product", {8'b0, p4}, 16'd225);
        @(posedge clk); #1;
        check("R2 one-cycle latency", {8'b0, p4}, 16'd63);

        // R3: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R3 mid-run reset", {8'b0, p4}, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        // wide combinational instance
        drive8(8'h00, 8'h00, "R8 zeros");
        drive8(8'hFF, 8'h00, "R8 zero multiplier");
        drive8(8'h00, 8'hFF, "R8 zero multiplicand");
        drive8(8'hFF, 8'hFF, "R7 R8 all ones");
        drive8(8'hAA, 8'h55, "R4 R5 alternating");
        drive8(8'h55, 8'hAA, "R4 R5 alternating");
        drive8(8'hAA, 8'hAA, "R5 alternating");
        drive8(8'hFF, 8'h81, "R6 long bypass run");
        drive8(8'hFF, 8'h83, "R6 carries into skipped rows");
        drive8(8'h80, 8'hFF, "R5 single column");
        drive8(8'hFF, 8'h01, "R4 only first row");
        drive8(8'h7F, 8'hC7, "R2 combinational");
        for (int k = 0; k < 400; k++) begin
            drive8(8'($urandom), 8'($urandom), "R1 random");
        end

        done = 1'b1;
        finish_run();
    end
endmodule